// File: doc/BRIEF.md
# Wavefront Control-Flow Issue Scheduler

This block sits at the front of one compute unit. It holds a set of ready wavefronts and issues control-flow instructions from them, one instruction per cycle at most. In each cycle it scans the ready set in round-robin order and proposes one wavefront. It requests that wavefront's next instruction kind and either issues it or stalls it. An issued wavefront leaves the ready set and stays out until its instruction retires, so at most one control-flow instruction is ever outstanding per wavefront and no speculation is needed.

Two instruction kinds start a secondary clause, one arithmetic and one fetch. Each claims its engine and holds it until the engine's done pulse arrives. Plain control-flow and global-write instructions need no engine and count as finished once issued. Completion order is kept in a queue of issued wavefronts. Only the oldest entry may retire, and a retiring wavefront rejoins the ready set unless its instruction was marked as the end of its program.

Top module: `wfs_cf_sched`

## Requirements
- R1: After reset the ready set is empty, nothing is issued or retired and both engines are free.
- R2: A wavefront whose bit is set in `launch_mask` is in `pool_map` from the next cycle, and can issue in that cycle.
- R3: The proposed wavefront is the first ready ID after the last proposed one, wrapping from NUM_WF-1 to 0. The pointer starts at NUM_WF-1, so ID 0 comes first after reset.
- R4: Issuing removes the wavefront from the ready set in the next cycle, and it is not proposed again before its instruction retires.
- R5: Kind 2'b01 (arithmetic clause) and kind 2'b10 (fetch clause) raise the busy output of their engine from the cycle after issue. Busy stays high until the cycle after that engine's done pulse.
- R6: Kind 2'b00 (plain) and kind 2'b11 (global write) claim no engine and may issue while either engine is busy.
- R7: When the proposed wavefront needs a busy engine, nothing issues in that cycle and the wavefront stays in the ready set. The next proposal starts after that wavefront.
- R8: Retirement follows issue order. A finished instruction waits while an older one is still unfinished.
- R9: A retiring wavefront whose instruction had `fetch_end` low is back in `pool_map` in the next cycle.
- R10: While one wavefront holds an engine, other wavefronts whose instructions need a free engine keep issuing.
- R11: Clause-kind instructions become ready to retire from the cycle after their engine's done pulse. Plain and write kinds are ready from the cycle after issue.
- R12: A retiring wavefront whose instruction had `fetch_end` high does not rejoin the ready set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_mask | input | NUM_WF | Wavefronts to add to the ready set |
| fetch_req | output | 1 | A ready wavefront is proposed this cycle |
| fetch_wf | output | IDW | Proposed wavefront ID |
| fetch_kind | input | 2 | Kind of the proposed wavefront's next instruction |
| fetch_end | input | 1 | That instruction ends the wavefront's program |
| issue_valid | output | 1 | Instruction issued this cycle |
| issue_wf | output | IDW | Issued wavefront ID |
| issue_kind | output | 2 | Issued instruction kind |
| alu_done | input | 1 | Arithmetic clause finished (pulse) |
| tex_done | input | 1 | Fetch clause finished (pulse) |
| alu_busy | output | 1 | Arithmetic engine held |
| tex_busy | output | 1 | Fetch engine held |
| retire_valid | output | 1 | Oldest instruction retires this cycle |
| retire_wf | output | IDW | Retiring wavefront ID |
| pool_map | output | NUM_WF | Ready-set bitmap |

## Verification
The bench first runs four plain end-of-program wavefronts. Their issue sequence shows the round-robin order, and the lack of re-entry into the ready set shows that end marking works. A single looping wavefront shows that a retired wavefront rejoins the ready set and issues again. A mix of two arithmetic-clause wavefronts and one fetch-clause wavefront separates an engine stall from an issue. The same mix shows the pointer advancing past a stalled wavefront, the other engine still issuing, and a finished younger instruction held behind an unfinished older one. A last pattern issues a global write while the arithmetic engine is held, and shows that writes claim no engine.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

   typedef enum logic [1:0] {
      CF_PLAIN  = 2'b00,
      CF_ALU    = 2'b01,
      CF_TEX    = 2'b10,
      CF_GWRITE = 2'b11
   } cf_kind_e;

   localparam int NUM_ENG = 2;

   // engine index -> instruction kind that claims it
   function automatic logic [1:0] eng_kind(input int e);
      return (e == 0) ? CF_ALU : CF_TEX;
   endfunction

   function automatic logic kind_needs_engine(input logic [1:0] k);
      return (k == CF_ALU) || (k == CF_TEX);
   endfunction

endpackage

// File: rtl/wfs_rr_pick.sv
module wfs_rr_pick #(
   parameter int N   = 8,
   parameter int IDW = 3
) (
   input  logic [N-1:0]   req_i,
   input  logic [IDW-1:0] last_i,
   output logic           found_o,
   output logic [IDW-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = 1; k <= N; k++) begin
         int j;
         j = (int'(last_i) + k) % N;
         if (!found_o && req_i[j]) begin
            found_o = 1'b1;
            idx_o   = IDW'(j);
         end
      end
   end

endmodule

// File: rtl/wfs_eng_track.sv
module wfs_eng_track (
   input  logic clk,
   input  logic rst_n,
   input  logic claim_i,
   input  logic release_i,
   output logic busy_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_o <= 1'b0;
      else if (claim_i)   busy_o <= 1'b1;
      else if (release_i) busy_o <= 1'b0;
   end

   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_i |-> !busy_o);
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !release_i) |=> busy_o);
   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !claim_i) |=> !busy_o);

endmodule

// File: rtl/wfs_order_fifo.sv
module wfs_order_fifo
   import wfs_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int IDW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic [IDW-1:0]     push_id_i,
   input  logic [1:0]         push_kind_i,
   input  logic               push_last_i,
   input  logic [NUM_ENG-1:0] mark_i,
   output logic               head_ready_o,
   output logic [IDW-1:0]     head_id_o,
   output logic               head_last_o
);

   localparam int PW = $clog2(DEPTH);

   typedef struct packed {
      logic           vld;
      logic           done;
      logic           last;
      logic [1:0]     kind;
      logic [IDW-1:0] id;
   } entry_t;

   entry_t        ent_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [PW:0]   cnt_q;
   logic          pop;

   assign head_ready_o = ent_q[rd_q].vld && ent_q[rd_q].done;
   assign head_id_o    = ent_q[rd_q].id;
   assign head_last_o  = ent_q[rd_q].last;
   assign pop          = head_ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            for (int e = 0; e < NUM_ENG; e++) begin
               if (mark_i[e] && ent_q[i].vld && ent_q[i].kind == eng_kind(e))
                  ent_q[i].done <= 1'b1;
            end
         end
         if (pop) begin
            ent_q[rd_q].vld <= 1'b0;
            rd_q            <= rd_q + 1'b1;
         end
         if (push_i) begin
            ent_q[wr_q] <= '{vld: 1'b1, done: !kind_needs_engine(push_kind_i),
                             last: push_last_i, kind: push_kind_i, id: push_id_i};
            wr_q        <= wr_q + 1'b1;
         end
         cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop);
      end
   end

   logic id_present;
   always_comb begin
      id_present = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (ent_q[i].vld && ent_q[i].id == push_id_i) id_present = 1'b1;
   end

   p_one_inflight_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !id_present);
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop) |-> (cnt_q < (PW+1)'(DEPTH)));

endmodule

// File: rtl/wfs_cf_sched.sv
module wfs_cf_sched
   import wfs_pkg::*;
#(
   parameter  int NUM_WF = 8,
   localparam int IDW    = $clog2(NUM_WF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_WF-1:0] launch_mask,
   output logic              fetch_req,
   output logic [IDW-1:0]    fetch_wf,
   input  logic [1:0]        fetch_kind,
   input  logic              fetch_end,
   output logic              issue_valid,
   output logic [IDW-1:0]    issue_wf,
   output logic [1:0]        issue_kind,
   input  logic              alu_done,
   input  logic              tex_done,
   output logic              alu_busy,
   output logic              tex_busy,
   output logic              retire_valid,
   output logic [IDW-1:0]    retire_wf,
   output logic [NUM_WF-1:0] pool_map
);

   if (NUM_WF < 2 || (NUM_WF & (NUM_WF - 1)) != 0) begin : g_bad_num_wf
      $error("NUM_WF must be a power of two of at least 2");
   end

   logic [NUM_WF-1:0]  pool_q;
   logic [IDW-1:0]     last_q;
   logic               found;
   logic [IDW-1:0]     pick;
   logic [NUM_ENG-1:0] eng_busy, eng_need, eng_done;
   logic               blocked;
   logic               retire_last;

   wfs_rr_pick #(.N(NUM_WF), .IDW(IDW)) i_pick (
      .req_i  (pool_q),
      .last_i (last_q),
      .found_o(found),
      .idx_o  (pick)
   );

   assign eng_done = {tex_done, alu_done};

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      assign eng_need[e] = (fetch_kind == eng_kind(e));
      wfs_eng_track i_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .claim_i  (issue_valid && eng_need[e]),
         .release_i(eng_done[e]),
         .busy_o   (eng_busy[e])
      );
   end

   assign blocked     = |(eng_need & eng_busy);
   assign fetch_req   = found;
   assign fetch_wf    = pick;
   assign issue_valid = found && !blocked;
   assign issue_wf    = pick;
   assign issue_kind  = fetch_kind;
   assign alu_busy    = eng_busy[0];
   assign tex_busy    = eng_busy[1];
   assign pool_map    = pool_q;

   wfs_order_fifo #(.DEPTH(NUM_WF), .IDW(IDW)) i_order (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (issue_valid),
      .push_id_i   (pick),
      .push_kind_i (fetch_kind),
      .push_last_i (fetch_end),
      .mark_i      (eng_done),
      .head_ready_o(retire_valid),
      .head_id_o   (retire_wf),
      .head_last_o (retire_last)
   );

   logic [NUM_WF-1:0] take_oh, back_oh;
   always_comb begin
      take_oh = '0;
      back_oh = '0;
      if (issue_valid)                 take_oh[pick]      = 1'b1;
      if (retire_valid && !retire_last) back_oh[retire_wf] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pool_q <= '0;
         last_q <= IDW'(NUM_WF - 1);
      end else begin
         pool_q <= (pool_q & ~take_oh) | back_oh | launch_mask;
         if (found) last_q <= pick;
      end
   end

   p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && !retire_last) |=> pool_q[$past(retire_wf)]);
   p_stall_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !issue_valid) |=> pool_q[$past(fetch_wf)]);
   p_leave_pool_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !launch_mask[issue_wf]) |=> !pool_q[$past(issue_wf)]);

endmodule

// File: tb/test_wfs_cf_sched.sv
module test_wfs_cf_sched;

   localparam int NW  = 8;
   localparam int IDW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NW-1:0]  launch_mask = '0;
   logic           fetch_req, fetch_end;
   logic [IDW-1:0] fetch_wf, issue_wf, retire_wf;
   logic [1:0]     fetch_kind, issue_kind;
   logic           issue_valid, alu_done = 1'b0, tex_done = 1'b0;
   logic           alu_busy, tex_busy, retire_valid;
   logic [NW-1:0]  pool_map;

   logic [1:0] kind_tab [NW];
   logic       end_tab  [NW];

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];

   always #10 clk = ~clk;

   assign fetch_kind = kind_tab[fetch_wf];
   assign fetch_end  = end_tab[fetch_wf];

   wfs_cf_sched #(.NUM_WF(NW)) i_wfs_cf_sched (
      .clk(clk), .rst_n(rst_n), .launch_mask(launch_mask),
      .fetch_req(fetch_req), .fetch_wf(fetch_wf), .fetch_kind(fetch_kind),
      .fetch_end(fetch_end), .issue_valid(issue_valid), .issue_wf(issue_wf),
      .issue_kind(issue_kind), .alu_done(alu_done), .tex_done(tex_done),
      .alu_busy(alu_busy), .tex_busy(tex_busy), .retire_valid(retire_valid),
      .retire_wf(retire_wf), .pool_map(pool_map)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // start of a cycle: clear one-cycle inputs
   task automatic cyc();
      @(posedge clk);
      #1;
      launch_mask = '0;
      alu_done    = 1'b0;
      tex_done    = 1'b0;
   endtask

   task automatic settle();
      #8;
   endtask

   // driver: check the issue and record the expected retirement
   task automatic exp_issue(input string tag, input int wf);
      check({tag, " issue_valid"}, int'(issue_valid), 1);
      check({tag, " issue_wf"}, int'(issue_wf), wf);
      if (issue_valid) exp_q.push_back(int'(issue_wf));
   endtask

   // monitor: retirements must match issue order
   always @(negedge clk) begin
      if (rst_n && retire_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R8: actual retire %0d expected none", retire_wf);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(retire_wf) != e) begin
               n_fail++;
               $display("FAIL R8: actual retire %0d expected %0d", retire_wf, e);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NW; i++) begin
         kind_tab[i] = 2'b00;
         end_tab[i]  = 1'b1;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      cyc(); settle();
      check("R1 pool", int'(pool_map), 0);
      check("R1 issue", int'(issue_valid), 0);
      check("R1 retire", int'(retire_valid), 0);
      check("R1 busy", int'({alu_busy, tex_busy}), 0);

      // A: four plain end-of-program wavefronts, R2 R3 R12
      cyc(); launch_mask = 8'h0F; settle();
      cyc(); settle();
      check("R2 pool", int'(pool_map), 8'h0F);
      exp_issue("R3 a0", 0);
      cyc(); settle(); exp_issue("R3 a1", 1);
      cyc(); settle(); exp_issue("R3 a2", 2);
      check("R12 pool no return", int'(pool_map), 8'h0C);
      cyc(); settle(); exp_issue("R3 a3", 3);
      cyc(); settle();
      check("R4 nothing left", int'(issue_valid), 0);
      cyc(); settle();
      check("R12 pool empty", int'(pool_map), 0);

      // B: one looping wavefront, R9 R11
      end_tab[5] = 1'b0;
      cyc(); launch_mask = 8'h20; settle();
      cyc(); settle(); exp_issue("R2 b0", 5);
      cyc(); settle();
      check("R4 not reissued", int'(issue_valid), 0);
      check("R11 plain ready", int'(retire_valid), 1);
      end_tab[5] = 1'b1;
      cyc(); settle();
      check("R9 back in pool", int'(pool_map), 8'h20);
      exp_issue("R9 reissue", 5);
      cyc(); settle();
      cyc(); settle();
      check("R12 b pool empty", int'(pool_map), 0);

      // C: engine contention, R5 R7 R8 R10 R11
      kind_tab[1] = 2'b01; kind_tab[2] = 2'b01; kind_tab[3] = 2'b10;
      cyc(); launch_mask = 8'h0E; settle();
      cyc(); settle(); exp_issue("R3 wrap", 1);
      cyc(); settle();
      check("R5 alu busy", int'(alu_busy), 1);
      check("R7 stall", int'(issue_valid), 0);
      check("R7 fetch_wf", int'(fetch_wf), 2);
      cyc(); settle();
      exp_issue("R10 tex past stall", 3);
      check("R7 kept", int'(pool_map[2]), 1);
      cyc(); alu_done = 1'b1; settle();
      check("R7 still stalled", int'(issue_valid), 0);
      check("R5 tex busy", int'(tex_busy), 1);
      check("R11 not ready", int'(retire_valid), 0);
      cyc(); settle();
      exp_issue("R11 alu free", 2);
      check("R11 retire", int'(retire_valid), 1);
      cyc(); alu_done = 1'b1; settle();
      check("R5 alu held", int'(alu_busy), 1);
      check("R8 head waits", int'(retire_valid), 0);
      cyc(); tex_done = 1'b1; settle();
      check("R8 younger done waits", int'(retire_valid), 0);
      check("R5 alu cleared", int'(alu_busy), 0);
      cyc(); settle();
      check("R5 tex cleared", int'(tex_busy), 0);
      cyc(); settle();
      cyc(); settle();

      // D: global write while arithmetic engine held, R6
      kind_tab[4] = 2'b01; kind_tab[6] = 2'b11;
      cyc(); launch_mask = 8'h50; settle();
      cyc(); settle(); exp_issue("R6 alu", 4);
      cyc(); settle(); exp_issue("R6 write", 6);
      check("R6 tex free", int'(tex_busy), 0);
      cyc(); alu_done = 1'b1; settle();
      check("R8 write waits", int'(retire_valid), 0);
      repeat (3) begin cyc(); settle(); end

      check("R8 queue drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule